// File: doc/BRIEF.md
# Partial Word Store Byte Aligner

This block turns a store-bytes request into exactly one write beat on a big-endian memory port that carries eight byte lanes. A request gives a byte address, a register value, a direction select and a unit-size select. The direction select picks begin or end mode. The size select picks a 4-byte word unit or an 8-byte doubleword unit. Begin mode covers the span from the addressed byte up to the last byte of the aligned unit. End mode covers the span from the first byte of the aligned unit up to, but not including, the addressed byte.

The block places the value on the lanes and builds the per-lane byte enables from the low address bits. A partial write of 3, 5, 6 or 7 bytes is never split into smaller writes, so memory sees it as one atomic masked write. An end-mode request at a unit boundary covers no bytes. It is still issued as a beat with an all-zero enable and a probe flag, so that the downstream side can check protection and mark the line dirty. Each accepted request is held in one output register until the port accepts it.

Top module: `psa_aligner`

## Requirements
- R1: After reset, `wr_valid` is low and `req_ready` is high.
- R2: Begin mode, word size: with k = addr[1:0], the enabled lanes are unit bytes k..3 of the addressed word. Offset 0 enables 4 lanes. Offset 1 enables 3 lanes, the 0x00FFFFFF word mask. Offset 3 enables one lane, which carries the least significant byte of the value.
- R3: End mode, word size: with k = addr[1:0], the enabled lanes are unit bytes 0..k-1. They carry the k most significant bytes of the 32-bit value, with the most significant byte at the lowest address. Offset 3 enables 3 lanes, the 0xFFFFFF00 word mask.
- R4: End mode with unit offset 0 gives `wr_be` = 0 and `wr_probe` = 1. Every other request gives `wr_probe` = 0 and a non-zero `wr_be`.
- R5: Doubleword size uses k = addr[2:0] over all 8 lanes. Begin mode enables lanes k..7, which are the low 8-k bytes of the value. End mode enables lanes 0..k-1, which are the high k bytes.
- R6: Word size enables lanes only in the addressed half: lanes 0..3 when addr[2]=0, lanes 4..7 when addr[2]=1. `wr_data` carries value[31:0] in both halves.
- R7: Lane i (bit i of `wr_be`) is the byte at address (addr & ~7) + i and is carried on `wr_data[63-8i -: 8]`. In doubleword size, `wr_data` equals the value.
- R8: `wr_addr` is the request address with its low 2 bits (word) or low 3 bits (doubleword) cleared.
- R9: Each accepted request yields exactly one write beat, one cycle after acceptance.
- R10: `req_ready` equals `!wr_valid || wr_ready`. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data`, `wr_be` and `wr_probe` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Byte address of the store |
| req_value | input | 64 | Register value (word size uses bits 31:0) |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| req_dword | input | 1 | 0 = 4-byte unit, 1 = 8-byte unit |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | ADDR_W | Unit-aligned write address |
| wr_data | output | 64 | Big-endian lane data |
| wr_be | output | 8 | Byte enable, bit i = lane i |
| wr_probe | output | 1 | Empty end-mode store: probe only |

## Verification
The bench builds the block with ADDR_W set to 16. At that width, random addresses also exercise the upper address bits that the rounding must keep, and the address field stays short enough to read in failure lines. Every offset from 0 to 7 is swept for both modes and both unit sizes. Spot checks use literal enable masks: 3-byte masks in both halves of the port, a 5-byte doubleword end store and a 7-byte doubleword begin store. A long phase then toggles `wr_ready` pseudo-randomly. This places requests against a stalled output and checks that the held beat does not change.

// File: rtl/psa_pkg.sv
package psa_pkg;
    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int HALF   = LANES / 2;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic {
        DIR_BEGIN = 1'b0,
        DIR_END   = 1'b1
    } dir_e;
endpackage

// File: rtl/psa_lane_mask.sv
module psa_lane_mask
    import psa_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  dir_e             dir,
    input  logic             is_dword,
    output logic [LANES-1:0] be,
    output logic             probe
);
    logic [OFF_W-1:0] unit_off;

    always_comb begin
        unit_off = is_dword ? offset : {1'b0, offset[OFF_W-2:0]};
        probe    = (dir == DIR_END) && (unit_off == '0);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int REL_W = i % HALF;
        localparam logic UPPER = (i >= HALF);
        logic             in_unit;
        logic [OFF_W-1:0] rel;
        always_comb begin
            in_unit = is_dword || (offset[OFF_W-1] == UPPER);
            rel     = is_dword ? OFF_W'(i) : OFF_W'(REL_W);
            if (dir == DIR_END)
                be[i] = in_unit && (rel < unit_off);
            else
                be[i] = in_unit && (rel >= unit_off);
        end
    end

    // R4
    always_comb begin
        probe_excl_chk: assert (!(probe && (|be)));
    end
endmodule

// File: rtl/psa_data_place.sv
module psa_data_place
    import psa_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    input  logic              is_dword,
    output logic [DATA_W-1:0] data
);
    localparam int HW = DATA_W / 2;

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_comb begin
            if (is_dword)
                data[h*HW +: HW] = value[h*HW +: HW];
            else
                data[h*HW +: HW] = value[HW-1:0];
        end
    end
endmodule

// File: rtl/psa_aligner.sv
module psa_aligner
    import psa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_value,
    input  logic              req_end,
    input  logic              req_dword,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [63:0]       wr_data,
    output logic [7:0]        wr_be,
    output logic              wr_probe
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  be;
        logic              probe;
        logic              dword;
    } beat_t;

    beat_t            st_d, st_q;
    logic [LANES-1:0] mask_w;
    logic             probe_w;
    logic [DATA_W-1:0] data_w;
    logic             accept;
    dir_e             dir_w;

    assign dir_w = dir_e'(req_end);

    psa_lane_mask u_mask (
        .offset   (req_addr[OFF_W-1:0]),
        .dir      (dir_w),
        .is_dword (req_dword),
        .be       (mask_w),
        .probe    (probe_w)
    );

    psa_data_place u_place (
        .value    (req_value),
        .is_dword (req_dword),
        .data     (data_w)
    );

    always_comb begin
        req_ready = !st_q.valid || wr_ready;
        accept    = req_valid && req_ready;
        st_d      = st_q;
        if (wr_ready) st_d.valid = 1'b0;
        if (accept) begin
            st_d.valid = 1'b1;
            st_d.addr  = {req_addr[ADDR_W-1:OFF_W],
                          req_dword ? 1'b0 : req_addr[OFF_W-1],
                          {(OFF_W-1){1'b0}}};
            st_d.data  = data_w;
            st_d.be    = mask_w;
            st_d.probe = probe_w;
            st_d.dword = req_dword;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_valid = st_q.valid;
    assign wr_addr  = st_q.addr;
    assign wr_data  = st_q.data;
    assign wr_be    = st_q.be;
    assign wr_probe = st_q.probe;

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                     && $stable(wr_be) && $stable(wr_probe)));
    // R8
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));
    // R6
    half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !st_q.dword) |-> (wr_be[7:4] == 4'h0 || wr_be[3:0] == 4'h0));
    // R4
    probe_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_probe == (wr_be == 8'h00)));
    // R9
    one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> wr_valid);
endmodule

// File: tb/psa_aligner_bench.sv
module psa_aligner_bench;
    localparam int AW = 16;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          req_valid = 0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_value = '0;
    logic          req_end = 0;
    logic          req_dword = 0;
    logic          wr_valid;
    logic          wr_ready = 1;
    logic [AW-1:0] wr_addr;
    logic [63:0]   wr_data;
    logic [7:0]    wr_be;
    logic          wr_probe;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [63:0]   data;
        logic [7:0]    be;
        logic          probe;
        logic          dword;
        logic          e;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    psa_aligner #(.ADDR_W(AW)) u_psa_aligner (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_value(req_value), .req_end(req_end),
        .req_dword(req_dword), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_probe(wr_probe)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic exp_t model(input int addr, input logic [63:0] v, input bit e, input bit dw);
        exp_t r;
        int off, base, n;
        off  = dw ? (addr % 8) : (addr % 4);
        base = dw ? 0 : ((addr / 4) % 2) * 4;
        n    = dw ? 8 : 4;
        r.be = 8'h00;
        for (int j = 0; j < n; j++)
            r.be[base + j] = e ? (j < off) : (j >= off);
        r.data  = dw ? v : {v[31:0], v[31:0]};
        r.addr  = AW'(addr - (dw ? addr % 8 : addr % 4));
        r.probe = e && (off == 0);
        r.dword = dw;
        r.e     = e;
        return r;
    endfunction

    // Compare at the current negedge, drive, advance the model, go to next negedge.
    task automatic cycle(input bit rv, input int addr, input logic [63:0] v,
                         input bit e, input bit dw, input bit rdy);
        string tg;
        check("R10 req_ready", 64'(req_ready), 64'(q.size() == 0 || wr_ready));
        check("R9 wr_valid", 64'(wr_valid), 64'(q.size() != 0));
        if (q.size() != 0 && wr_valid) begin
            tg = q[0].probe ? "R4" : (q[0].dword ? "R5" : (q[0].e ? "R3" : "R2"));
            check({tg, " wr_be"}, 64'(wr_be), 64'(q[0].be));
            check("R4 wr_probe", 64'(wr_probe), 64'(q[0].probe));
            check("R8 wr_addr", 64'(wr_addr), 64'(q[0].addr));
            check(q[0].dword ? "R7 wr_data" : "R6 wr_data", wr_data, q[0].data);
        end
        req_valid = rv; req_addr = AW'(addr); req_value = v;
        req_end = e; req_dword = dw; wr_ready = rdy;
        begin
            bit mready;
            mready = (q.size() == 0) || rdy;
            if (q.size() != 0 && rdy) void'(q.pop_front());
            if (rv && mready) q.push_back(model(addr, v, e, dw));
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic one(input int addr, input bit e, input bit dw, input logic [7:0] lit, input string tag);
        cycle(1, addr, 64'h0123_4567_89AB_CDEF, e, dw, 1);
        check(tag, 64'(wr_be), 64'(lit));
        cycle(0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 wr_valid", 64'(wr_valid), 64'(0));
        check("R1 req_ready", 64'(req_ready), 64'(1));
        rst_n = 1;
        @(negedge clk);

        // Literal mask spot checks
        one(16'h1001, 0, 0, 8'h0E, "R2 begin word off1 (0x00FFFFFF)");
        one(16'h1007, 1, 0, 8'h70, "R3 end word upper half off3 (0xFFFFFF00)");
        one(16'h2004, 1, 0, 8'h00, "R4 end word off0 probe");
        one(16'h2003, 0, 0, 8'h08, "R2 begin word off3 one byte");
        one(16'h3005, 1, 1, 8'h1F, "R5 end dword off5");
        one(16'h3001, 0, 1, 8'hFE, "R5 begin dword off1 seven bytes");
        one(16'h3006, 0, 0, 8'hC0, "R6 begin word upper half off2");

        // Sweep all offsets, modes, sizes
        for (int dw = 0; dw < 2; dw++)
            for (int e = 0; e < 2; e++)
                for (int a = 0; a < 8; a++)
                    cycle(1, 16'h4A50 + a, {32'hA1B2C3D4, 32'h5E6F7081} + 64'(a),
                          bit'(e), bit'(dw), 1);
        cycle(0, 0, 0, 0, 0, 1);

        // Back-pressure phase
        for (int n = 0; n < 600; n++)
            cycle(bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 65535)),
                  {$urandom, $urandom}, bit'($urandom_range(0, 1)),
                  bit'($urandom_range(0, 1)), bit'($urandom_range(0, 2) != 0));
        for (int n = 0; n < 3; n++) cycle(0, 0, 0, 0, 0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule